// File: doc/BRIEF.md
# Timer-Triggered Parallel Pulse Generator

This block drives a group of parallel output pins whose levels move in lock-step with a periodic timer event. A free-running up-counter is fed by a selectable power-of-two prescaler. It is compared against a bank of compare registers. One of those compare matches is chosen as the output trigger. Compare register 0 can also be chosen to clear the counter, and that sets the trigger period.

Software holds the next pattern in a staging register. On each selected trigger, the staging value moves into the pin data register. This happens only for the bits whose direction bit and pulse-enable bit are both set. All other bits keep their value, and software may write them directly at any time. Each trigger also raises a sticky flag, which can be routed to an interrupt line. Software uses that interrupt to load the following pattern before the next event. Pins whose direction bit is 0 are released, which is shown on an output-enable vector.

All configuration arrives over a simple write-only register port: write enable, address and data.

Top module: `pgen_top`

## Requirements
- R1: While reset is high, and after it is released, the pin data, the output-enable vector, the sticky flag and the interrupt are all 0, and the counter is stopped.
- R2: The counter does not advance and no trigger occurs while the start bit (bit 0 of the control register, address 0) is 0. The pins keep the value last written to the pin data register (address 3).
- R3: While running, the counter advances once every 2^PS clocks. PS is the 3-bit field in bits 3:1 of the control register.
- R4: When clear-on-match (control bit 4) is 1, the counter returns to 0 on the advance cycle in which it equals compare register 0 (address 8). This gives a trigger period of (compare0+1)*2^PS clocks. When the bit is 0, the counter keeps counting past that value.
- R5: The trigger-select field (control bits 6:5) picks which compare register i (address 8+i) produces the trigger. A match is an advance cycle in which the counter equals that register.
- R6: On a trigger, each bit whose direction bit (address 1) and pulse-enable bit (address 2) are both 1 takes the staging value (address 4). Every other bit keeps its value. The pins show the result one clock after the match cycle.
- R7: A write to the pin data register (address 3) sets every bit directly. If a trigger falls in the same cycle, the trigger value wins for the pulse bits.
- R8: A trigger sets the sticky flag. The interrupt output equals the flag gated by the interrupt-enable bit (control bit 7).
- R9: Writing 1 to bit 0 of the status address (address 5) clears the flag. A trigger in the same cycle as the clear leaves the flag set.
- R10: The output-enable vector equals the direction register. A bit at 0 means that pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DW (16) | Register write data |
| pin_o | output | W (8) | Pin data levels |
| pin_oe_o | output | W (8) | Per-pin output enable |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 1 | Sticky trigger flag |

## Verification
The hardest cases to reach are two same-cycle collisions. In the first, a software write lands on the exact clock in which the selected compare match happens. In the second, a flag clear coincides with a new trigger. Each test resets the block, so the clock count from the start-bit write to every match is known exactly. Each test then times the colliding write so that it commits on the computed match edge. The bench also waits past the point where a cleared counter would have fired again, so it can tell clear-on-match apart from free-running counting.

// File: rtl/pgen_pkg.sv
package pgen_pkg;
  localparam int ADDR_W = 4;
  localparam int PS_W   = 3;
  localparam int TSEL_W = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIR  = 4'd1;
  localparam logic [ADDR_W-1:0] A_NDE  = 4'd2;
  localparam logic [ADDR_W-1:0] A_ODR  = 4'd3;
  localparam logic [ADDR_W-1:0] A_NDR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd5;
  localparam int                A_CMP0 = 8;

  typedef struct packed {
    logic              ie;
    logic [TSEL_W-1:0] tsel;
    logic              clr;
    logic [PS_W-1:0]   ps;
    logic              start;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/pgen_regs.sv
module pgen_regs
  import pgen_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 16,
  parameter int NC = 4,
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DW-1:0]         wr_data,
  output ctrl_t                 ctrl,
  output logic [W-1:0]          dir,
  output logic [W-1:0]          nde,
  output logic [W-1:0]          ndr,
  output logic [NC-1:0][CW-1:0] cmp,
  output logic                  odr_wr,
  output logic                  flag_clr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      dir  <= '0;
      nde  <= '0;
      ndr  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_DIR:   dir  <= wr_data[W-1:0];
        A_NDE:   nde  <= wr_data[W-1:0];
        A_NDR:   ndr  <= wr_data[W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_cmp
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(A_CMP0 + i);
    always_ff @(posedge clk) begin
      if (rst)                             cmp[i] <= '0;
      else if (wr_en && wr_addr == MY_ADDR) cmp[i] <= wr_data[CW-1:0];
    end
  end

  assign odr_wr   = wr_en && (wr_addr == A_ODR);
  assign flag_clr = wr_en && (wr_addr == A_STAT) && wr_data[0];
endmodule

// File: rtl/pgen_prescale.sv
module pgen_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] sel,
  output logic            tick
);
  localparam int PRE_W = (2 ** PS_W) - 1;

  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || !run) pre <= '0;
    else             pre <= pre + PRE_W'(1);
  end

  assign mask = ~({PRE_W{1'b1}} << sel);
  assign tick = run && ((pre & mask) == mask);
endmodule

// File: rtl/pgen_timer.sv
module pgen_timer #(
  parameter int CW = 16,
  parameter int NC = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  clr,
  input  logic [NC-1:0][CW-1:0] cmp,
  output logic [CW-1:0]         cnt,
  output logic [NC-1:0]         match
);
  for (genvar i = 0; i < NC; i++) begin : g_match
    assign match[i] = tick && (cnt == cmp[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (tick) begin
      if (clr && match[0])    cnt <= '0;
      else                    cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/pgen_out.sv
module pgen_out #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         trig,
  input  logic [W-1:0] xmask,
  input  logic [W-1:0] ndr,
  input  logic         odr_wr,
  input  logic [W-1:0] odr_wdata,
  input  logic         flag_clr,
  output logic [W-1:0] odr,
  output logic         flag
);
  logic [W-1:0] odr_n;

  always_comb begin
    odr_n = odr;
    if (odr_wr) odr_n = odr_wdata;
    if (trig)   odr_n = (odr_n & ~xmask) | (ndr & xmask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odr  <= '0;
      flag <= 1'b0;
    end else begin
      odr <= odr_n;
      if (trig)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int W  = 8,
  parameter int CW = 16,
  parameter int NC = 4,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe_o,
  output logic              irq_o,
  output logic              flag_o
);
  ctrl_t                 ctrl;
  logic [W-1:0]          dir, nde, ndr, xmask;
  logic [NC-1:0][CW-1:0] cmp;
  logic                  odr_wr, flag_clr, tick, trig, run, clr, match0;
  logic [CW-1:0]         cnt;
  logic [NC-1:0]         match;

  pgen_regs #(.W(W), .CW(CW), .NC(NC), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl(ctrl), .dir(dir), .nde(nde), .ndr(ndr), .cmp(cmp),
    .odr_wr(odr_wr), .flag_clr(flag_clr)
  );

  assign run = ctrl.start;
  assign clr = ctrl.clr;

  pgen_prescale #(.PS_W(PS_W)) pre_i (
    .clk(clk), .rst(rst), .run(run), .sel(ctrl.ps), .tick(tick)
  );

  pgen_timer #(.CW(CW), .NC(NC)) tmr_i (
    .clk(clk), .rst(rst), .tick(tick), .clr(clr), .cmp(cmp),
    .cnt(cnt), .match(match)
  );

  assign match0 = match[0];

  always_comb begin
    trig = 1'b0;
    for (int i = 0; i < NC; i++)
      if (ctrl.tsel == TSEL_W'(i)) trig = match[i];
  end

  assign xmask = dir & nde;

  pgen_out #(.W(W)) out_i (
    .clk(clk), .rst(rst), .trig(trig), .xmask(xmask), .ndr(ndr),
    .odr_wr(odr_wr), .odr_wdata(wr_data[W-1:0]), .flag_clr(flag_clr),
    .odr(pin_o), .flag(flag_o)
  );

  assign pin_oe_o = dir;
  assign irq_o    = flag_o & ctrl.ie;
endmodule

// File: rtl/pgen_chk.sv
module pgen_chk #(
  parameter int W  = 8,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [3:0]    wr_addr,
  input logic [W-1:0]  wr_low,
  input logic [W-1:0]  pin_o,
  input logic [W-1:0]  pin_oe_o,
  input logic          irq_o,
  input logic          flag_o,
  input logic          trig,
  input logic [W-1:0]  xmask,
  input logic          odr_wr,
  input logic          flag_clr,
  input logic          ie,
  input logic          run,
  input logic          tick,
  input logic          clr,
  input logic          match0,
  input logic [CW-1:0] cnt
);
  p_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));
  p_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !(match0 && clr)) |=> cnt == $past(cnt) + CW'(1));
  p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (match0 && clr) |=> cnt == '0);
  p_pins_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (!trig && !odr_wr) |=> $stable(pin_o));
  p_plain_bits_r6: assert property (@(posedge clk) disable iff (rst)
    (trig && !odr_wr) |=> ((pin_o ^ $past(pin_o)) & ~$past(xmask)) == '0);
  p_trig_flag_r8: assert property (@(posedge clk) disable iff (rst)
    trig |=> flag_o);
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    !ie |-> !irq_o);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr) |=> flag_o);
  p_oe_dir_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'd1) |=> pin_oe_o == $past(wr_low));
endmodule

bind pgen_top pgen_chk #(.W(W), .CW(CW)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_low(wr_data[W-1:0]), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .irq_o(irq_o), .flag_o(flag_o), .trig(trig), .xmask(xmask),
  .odr_wr(odr_wr), .flag_clr(flag_clr), .ie(ctrl.ie), .run(run),
  .tick(tick), .clr(clr), .match0(match0), .cnt(cnt)
);

// File: tb/pgen_top_tb.sv
module pgen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  pin_o, pin_oe_o;
  logic        irq_o, flag_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pgen_top dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_o(pin_o), .pin_oe_o(pin_oe_o), .irq_o(irq_o), .flag_o(flag_o)
  );

  // control fields: bit0 start, bits3:1 prescale, bit4 clear, bits6:5 select, bit7 irq enable
  localparam logic [15:0] C_START = 16'h01;
  localparam logic [15:0] C_CLR   = 16'h10;
  localparam logic [15:0] C_IE    = 16'h80;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a falling edge; the write commits on the next rising edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 pins", pin_o, 0);
    check("R1 oe", pin_oe_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 flag", flag_o, 0);
    step(5);
    check("R1 pins idle", pin_o, 0);
  endtask

  task automatic t_stopped();
    do_reset();
    wr(4'd8, 16'd2); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd3, 16'h0F); wr(4'd4, 16'hA5); wr(4'd0, C_CLR);
    step(20);
    check("R2 pins hold stopped", pin_o, 8'h0F);
    check("R2 no flag stopped", flag_o, 0);
    check("R10 oe equals dir", pin_oe_o, 8'hFF);
  endtask

  task automatic t_basic();
    do_reset();
    wr(4'd8, 16'd3); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd3, 16'h00); wr(4'd4, 16'h5A);
    wr(4'd0, C_IE | C_CLR | C_START);   // commit edge E0
    step(3);
    check("R6 before match", pin_o, 8'h00);
    step(1);
    check("R6 first transfer", pin_o, 8'h5A);
    check("R8 flag set", flag_o, 1);
    check("R8 irq enabled", irq_o, 1);
    wr(4'd4, 16'hC3);                   // E5
    step(2);
    check("R4 no early repeat", pin_o, 8'h5A);
    step(1);
    check("R4 period four", pin_o, 8'hC3);
  endtask

  task automatic t_mask();
    do_reset();
    wr(4'd8, 16'd1); wr(4'd1, 16'h3F); wr(4'd2, 16'hCF);
    wr(4'd3, 16'h00); wr(4'd4, 16'hFF);
    wr(4'd0, C_CLR | C_START);
    step(1);
    check("R6 masked before", pin_o, 8'h00);
    step(1);
    check("R6 only dir&enable bits", pin_o, 8'h0F);
    check("R10 oe partial", pin_oe_o, 8'h3F);
  endtask

  task automatic t_prescale();
    do_reset();
    wr(4'd8, 16'd3); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd3, 16'h11); wr(4'd4, 16'h22);
    wr(4'd0, C_CLR | 16'h04 | C_START); // prescale 2 -> /4
    step(15);
    check("R3 before divided match", pin_o, 8'h11);
    step(1);
    check("R3 divided match", pin_o, 8'h22);
  endtask

  task automatic t_select();
    do_reset();
    wr(4'd8, 16'd5); wr(4'd9, 16'd1); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd3, 16'h00); wr(4'd4, 16'h33);
    wr(4'd0, C_CLR | 16'h20 | C_START); // select compare 1
    step(1);
    check("R5 before cmp1", pin_o, 8'h00);
    step(1);
    check("R5 cmp1 trigger", pin_o, 8'h33);
    wr(4'd4, 16'h44);                   // E3
    step(4);
    check("R5 hold until next", pin_o, 8'h33);
    step(1);
    check("R5 second trigger", pin_o, 8'h44);
  endtask

  task automatic t_noclear();
    do_reset();
    wr(4'd8, 16'd2); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd3, 16'h00); wr(4'd4, 16'h66);
    wr(4'd0, C_START);                  // no clear
    step(3);
    check("R4 free-run first match", pin_o, 8'h66);
    wr(4'd4, 16'h77);
    step(10);
    check("R4 no wrap without clear", pin_o, 8'h66);
  endtask

  task automatic t_irq_gate();
    do_reset();
    wr(4'd8, 16'd1); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd0, C_CLR | C_START);
    step(2);
    check("R8 flag without enable", flag_o, 1);
    check("R8 irq gated off", irq_o, 0);
  endtask

  task automatic t_flag();
    do_reset();
    wr(4'd8, 16'd3); wr(4'd1, 16'hFF); wr(4'd2, 16'hFF);
    wr(4'd0, C_IE | C_CLR | C_START);
    step(4);
    check("R9 flag set", flag_o, 1);
    wr(4'd5, 16'h1);                    // E5
    check("R9 cleared", flag_o, 0);
    check("R9 irq cleared", irq_o, 0);
    step(2);
    wr(4'd5, 16'h1);                    // commits on E8 with a match
    check("R9 set wins over clear", flag_o, 1);
  endtask

  task automatic t_odr_collide();
    do_reset();
    wr(4'd8, 16'd3); wr(4'd1, 16'hFF); wr(4'd2, 16'h0F);
    wr(4'd3, 16'h00); wr(4'd4, 16'hFF);
    wr(4'd0, C_CLR | C_START);
    step(3);
    wr(4'd3, 16'hAA);                   // commits on E4 with a match
    check("R7 trigger wins pulse bits", pin_o, 8'hAF);
    wr(4'd3, 16'h55);
    check("R7 direct write", pin_o, 8'h55);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_stopped();
    t_basic();
    t_mask();
    t_prescale();
    t_select();
    t_noclear();
    t_irq_gate();
    t_flag();
    t_odr_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule